// File: doc/BRIEF.md
# Host-Locked Trigger Timer Loop

This block keeps a local copy of the host's servo period inside the FPGA and locks it to the moment the host reads a dedicated sync register. That read is the first register access of every servo cycle. A phase counter runs from that read, and the loop's idea of when the next read will land is the point where the counter wraps back to zero. Each time the host reads the sync register, the block measures how far the real read fell from that predicted point. It limits that error to a programmable bound and low-pass filters the bounded value. It then adds a correction to the period estimate. Because the filter is slow, one late host read hardly moves the timebase.

Several trigger outputs hang off the same phase counter. Each trigger has its own signed offset, written in microseconds. A negative offset fires before the predicted read, so position counters can be latched or serial transfers started early enough to be complete when the host reads them. A positive offset fires after the read, for write-side actions. The raw phase error of the last accepted read is always visible on an output, so the host can see timing drift caused by system load.

The control is a three-state machine:
- `ST_IDLE` waits for the first sync read. The transition named *first-read* leads to `ST_RUN`.
- `ST_RUN` tracks. The transition named *capture* is a sync read, which leads to `ST_UPDATE`.
- `ST_UPDATE` applies the correction for exactly one clock. The transition named *apply* returns to `ST_RUN`.

Top module: `dpll_trigger_timer`

## Requirements
- R1: After reset and until the first sync read, every trigger is low and `phase_err` is zero. The first sync read leaves `phase_err` at zero and starts tracking.
- R2: The first sync read marks phase 0. The phase then advances by one per clock and wraps to 0 after reaching period−1, or on any clock where it is at or above period−1. Phase 0 is the predicted read.
- R3: A sync read accepted while the phase is v gives a raw error of v when 2v < period, and v − period otherwise. The raw error appears on `phase_err` as 24-bit two's complement from the clock after the read and holds until the next accepted read.
- R4: The raw error is clamped to ±limit before it feeds the loop, while `phase_err` still reports the unclamped value. The limit resets to 0x400000.
- R5: On the clock after an accepted read, the filter state f becomes f + ((b − f) >>> tc). Here b is the clamped error, >>> is an arithmetic shift, and tc resets to 10.
- R6: On that same clock, the period becomes period + f_new + (b >>> 4), saturated to the range [PER_MIN, 2^24−1].
- R7: Trigger i is high during the clock whose phase equals offset_i × US_TICKS taken modulo the period. It is computed as period + offset ticks when the offset is negative, which requires |offset ticks| < period. A negative offset therefore fires that many clocks before the predicted read.
- R8: A sync read that arrives during the update clock is ignored. `phase_err` and the timing are unchanged by it.
- R9: Write address 0 loads the period, raised to PER_MIN if smaller. Address 1 loads the limit, and address 2 loads tc from data bits [4:0]. Address 4+i loads the 16-bit signed offset of trigger i from data bits [15:0]. The period resets to PER_RST and the offsets reset to 0.
- R10: The update state lasts exactly one clock. A sync read on the clock right after it is accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_rd | input | 1 | One-clock strobe: the host read the sync register |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register write address |
| cfg_wdata | input | DATA_W | Register write data |
| trig | output | NUM_TRIG | One-clock trigger pulses |
| phase_err | output | DATA_W | Raw phase error of the last accepted sync read |

## Verification
The bench places sync reads on time, late and early, and checks the sign convention on both sides of the half-period split. A design that flipped the sign would steer the period the wrong way. It sets a small clamp limit and reads far off. A design that clamped the reported value would show the limit instead of the true error, and one that fed the raw error into the loop would move the trigger timing away from the bench's model. It sends back-to-back sync reads to check that the one arriving in the update clock is dropped, and that a read on the following clock is accepted. It then drives the period down onto its floor and measures the spacing between trigger pulses. A missing saturation would make that spacing collapse or wrap.

// File: rtl/dpll_trig_pkg.sv
package dpll_trig_pkg;

    // Loop control states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,   // no sync read seen yet
        ST_RUN    = 2'd1,   // tracking, waiting for the next sync read
        ST_UPDATE = 2'd2    // one clock: apply the correction
    } dpll_state_e;

endpackage

// File: rtl/dpll_cfg_regs.sv
module dpll_cfg_regs #(
    parameter int NUM_TRIG = 4,
    parameter int DATA_W   = 24,
    parameter int OFF_W    = 16,
    parameter int TC_W     = 5,
    parameter int ADDR_W   = 3,
    parameter int OFF_BASE = 4,
    parameter int PER_RST  = 50000,
    parameter int PER_MIN  = 8,
    parameter int LIM_RST  = 'h400000,
    parameter int TC_RST   = 10
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [DATA_W-1:0]                 wdata,
    input  logic                              upd_en,
    input  logic [DATA_W-1:0]                 per_next,
    output logic [DATA_W-1:0]                 period,
    output logic [DATA_W-1:0]                 limit,
    output logic [TC_W-1:0]                   tc,
    output logic [NUM_TRIG-1:0][OFF_W-1:0]    offs
);

    localparam logic [DATA_W-1:0] MIN_P = DATA_W'(PER_MIN);

    // A bus write to the period takes priority over the loop update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period <= DATA_W'(PER_RST);
        end else if (we && addr == ADDR_W'(0)) begin
            period <= (wdata < MIN_P) ? MIN_P : wdata;
        end else if (upd_en) begin
            period <= per_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit <= DATA_W'(LIM_RST);
            tc    <= TC_W'(TC_RST);
        end else if (we) begin
            if (addr == ADDR_W'(1)) limit <= wdata;
            if (addr == ADDR_W'(2)) tc    <= wdata[TC_W-1:0];
        end
    end

    for (genvar gi = 0; gi < NUM_TRIG; gi++) begin : g_off
        logic [OFF_W-1:0] off_r;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                off_r <= '0;
            end else if (we && addr == ADDR_W'(OFF_BASE + gi)) begin
                off_r <= wdata[OFF_W-1:0];
            end
        end
        assign offs[gi] = off_r;
    end

endmodule

// File: rtl/dpll_phase_track.sv
module dpll_phase_track #(
    parameter int DATA_W = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     run,
    input  logic [DATA_W-1:0]        period,
    output logic [DATA_W-1:0]        ph,
    output logic signed [DATA_W-1:0] raw_err
);

    // Phase counter: the first read is phase 0, so the next clock sees 1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph <= '0;
        end else if (start) begin
            ph <= DATA_W'(1);
        end else if (run) begin
            ph <= (ph >= period - 1'b1) ? '0 : ph + 1'b1;
        end else begin
            ph <= '0;
        end
    end

    // Late reads land just after the wrap, early reads just before it
    always_comb begin
        if ({ph, 1'b0} < {1'b0, period}) begin
            raw_err = ph;
        end else begin
            raw_err = ph - period;
        end
    end

endmodule

// File: rtl/dpll_loop_filter.sv
module dpll_loop_filter #(
    parameter int DATA_W  = 24,
    parameter int TC_W    = 5,
    parameter int PER_MIN = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cap_en,
    input  logic                     upd_en,
    input  logic signed [DATA_W-1:0] raw_err,
    input  logic [DATA_W-1:0]        limit,
    input  logic [TC_W-1:0]          tc,
    input  logic [DATA_W-1:0]        period,
    output logic signed [DATA_W-1:0] err_q,
    output logic [DATA_W-1:0]        per_next
);

    localparam int XW = DATA_W + 1;
    localparam int SW = DATA_W + 2;
    localparam logic signed [SW-1:0] MIN_S = SW'(PER_MIN);
    localparam logic signed [SW-1:0] MAX_S = SW'((1 << DATA_W) - 1);

    logic signed [XW-1:0]     err_x, lim_x, bnd_x, diff, step;
    logic signed [DATA_W-1:0] bnd_q, filt_q, filt_new, corr;
    logic signed [SW-1:0]     sum;

    // Bound the raw error to +/- limit
    always_comb begin
        err_x = {raw_err[DATA_W-1], raw_err};
        lim_x = {1'b0, limit};
        if (err_x > lim_x) begin
            bnd_x = lim_x;
        end else if (err_x < -lim_x) begin
            bnd_x = -lim_x;
        end else begin
            bnd_x = err_x;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q  <= '0;
            bnd_q  <= '0;
            filt_q <= '0;
        end else begin
            if (cap_en) begin
                err_q <= raw_err;
                bnd_q <= bnd_x[DATA_W-1:0];
            end
            if (upd_en) begin
                filt_q <= filt_new;
            end
        end
    end

    // First-order low-pass plus the bounded error divided by 16
    always_comb begin
        diff     = {bnd_q[DATA_W-1], bnd_q} - {filt_q[DATA_W-1], filt_q};
        step     = diff >>> tc;
        filt_new = filt_q + step[DATA_W-1:0];
        corr     = filt_new + (bnd_q >>> 4);
        sum      = {2'b00, period} + {{2{corr[DATA_W-1]}}, corr};
        if (sum < MIN_S) begin
            per_next = DATA_W'(PER_MIN);
        end else if (sum > MAX_S) begin
            per_next = MAX_S[DATA_W-1:0];
        end else begin
            per_next = sum[DATA_W-1:0];
        end
    end

endmodule

// File: rtl/dpll_offset_cmp.sv
module dpll_offset_cmp #(
    parameter int DATA_W   = 24,
    parameter int OFF_W    = 16,
    parameter int US_TICKS = 50
) (
    input  logic              active,
    input  logic [OFF_W-1:0]  offset,
    input  logic [DATA_W-1:0] period,
    input  logic [DATA_W-1:0] ph,
    output logic              fire
);

    localparam logic signed [DATA_W-1:0] K = DATA_W'(US_TICKS);

    logic signed [DATA_W-1:0] off_ext, off_t;
    logic [DATA_W-1:0]        off_u, tgt;

    // Offset in ticks, folded into one period around the predicted read
    always_comb begin
        off_ext = {{(DATA_W - OFF_W){offset[OFF_W-1]}}, offset};
        off_t   = off_ext * K;
        off_u   = off_t;
        tgt     = off_t[DATA_W-1] ? period + off_u : off_u;
        fire    = active && (ph == tgt);
    end

endmodule

// File: rtl/dpll_trigger_timer.sv
module dpll_trigger_timer
    import dpll_trig_pkg::*;
#(
    parameter int NUM_TRIG = 4,
    parameter int DATA_W   = 24,
    parameter int OFF_W    = 16,
    parameter int US_TICKS = 50,
    parameter int PER_RST  = 50000,
    parameter int PER_MIN  = 8,
    parameter int LIM_RST  = 'h400000,
    parameter int TC_RST   = 10,
    localparam int OFF_BASE = 4,
    localparam int ADDR_W   = $clog2(OFF_BASE + NUM_TRIG),
    localparam int TC_W     = $clog2(DATA_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sync_rd,
    input  logic                cfg_we,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [DATA_W-1:0]   cfg_wdata,
    output logic [NUM_TRIG-1:0] trig,
    output logic [DATA_W-1:0]   phase_err
);

    dpll_state_e state_q, state_d;
    logic start_go, cap_go, upd_go, run_go;

    logic [DATA_W-1:0]             period_w, limit_w, per_next_w, ph_w;
    logic [TC_W-1:0]               tc_w;
    logic [NUM_TRIG-1:0][OFF_W-1:0] offs_w;
    logic signed [DATA_W-1:0]      raw_err_w, err_q_w;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: first-read, capture, apply
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (sync_rd) state_d = ST_RUN;
            ST_RUN:    if (sync_rd) state_d = ST_UPDATE;
            ST_UPDATE: state_d = ST_RUN;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Per-state control outputs
    always_comb begin
        start_go = 1'b0;
        cap_go   = 1'b0;
        upd_go   = 1'b0;
        run_go   = 1'b0;
        unique case (state_q)
            ST_IDLE:   start_go = sync_rd;
            ST_RUN:    begin run_go = 1'b1; cap_go = sync_rd; end
            ST_UPDATE: begin run_go = 1'b1; upd_go = 1'b1; end
            default:   ;
        endcase
    end

    dpll_cfg_regs #(
        .NUM_TRIG(NUM_TRIG), .DATA_W(DATA_W), .OFF_W(OFF_W), .TC_W(TC_W),
        .ADDR_W(ADDR_W), .OFF_BASE(OFF_BASE), .PER_RST(PER_RST),
        .PER_MIN(PER_MIN), .LIM_RST(LIM_RST), .TC_RST(TC_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .upd_en(upd_go), .per_next(per_next_w), .period(period_w),
        .limit(limit_w), .tc(tc_w), .offs(offs_w)
    );

    dpll_phase_track #(.DATA_W(DATA_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .start(start_go), .run(run_go),
        .period(period_w), .ph(ph_w), .raw_err(raw_err_w)
    );

    dpll_loop_filter #(.DATA_W(DATA_W), .TC_W(TC_W), .PER_MIN(PER_MIN)) u_loop (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_go), .upd_en(upd_go),
        .raw_err(raw_err_w), .limit(limit_w), .tc(tc_w), .period(period_w),
        .err_q(err_q_w), .per_next(per_next_w)
    );

    for (genvar gi = 0; gi < NUM_TRIG; gi++) begin : g_trig
        dpll_offset_cmp #(.DATA_W(DATA_W), .OFF_W(OFF_W), .US_TICKS(US_TICKS)) u_cmp (
            .active(run_go), .offset(offs_w[gi]), .period(period_w),
            .ph(ph_w), .fire(trig[gi])
        );
    end

    assign phase_err = err_q_w;

endmodule

// File: rtl/dpll_trig_checks.sv
module dpll_trig_checks
    import dpll_trig_pkg::*;
#(
    parameter int NUM_TRIG = 4,
    parameter int DATA_W   = 24,
    parameter int PER_MIN  = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sync_rd,
    input logic [NUM_TRIG-1:0] trig,
    input logic [DATA_W-1:0]   phase_err,
    input dpll_state_e         state,
    input logic [DATA_W-1:0]   period,
    input logic [DATA_W-1:0]   ph
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (trig == '0 && phase_err == '0));

    p_phase_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && ph >= period - 1'b1) |=> (ph == '0));

    p_err_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_rd |=> $stable(phase_err));

    p_period_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        period >= DATA_W'(PER_MIN));

    p_ignore_in_update_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UPDATE) |=> $stable(phase_err));

    p_update_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UPDATE) |=> (state == ST_RUN));

    p_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && sync_rd) |=> (state == ST_UPDATE));

endmodule

bind dpll_trigger_timer dpll_trig_checks #(
    .NUM_TRIG(NUM_TRIG), .DATA_W(DATA_W), .PER_MIN(PER_MIN)
) u_checks (
    .clk(clk), .rst_n(rst_n), .sync_rd(sync_rd), .trig(trig),
    .phase_err(phase_err), .state(state_q), .period(period_w), .ph(ph_w)
);

// File: tb/test_dpll_trigger_timer.sv
module test_dpll_trigger_timer;

    localparam int NT   = 4;
    localparam int AW   = 3;
    localparam int DW   = 24;
    localparam int UT   = 2;
    localparam int PR   = 40;
    localparam int PMIN = 8;

    logic          clk = 1'b0;
    logic          rst_n, sync_rd, cfg_we;
    logic [AW-1:0] cfg_addr;
    logic [DW-1:0] cfg_wdata;
    wire  [NT-1:0] trig;
    wire  [DW-1:0] phase_err;

    always #10 clk = ~clk;   // 50 MHz

    dpll_trigger_timer #(
        .NUM_TRIG(NT), .DATA_W(DW), .US_TICKS(UT), .PER_RST(PR), .PER_MIN(PMIN)
    ) i_dpll_trigger_timer (
        .clk(clk), .rst_n(rst_n), .sync_rd(sync_rd), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .trig(trig), .phase_err(phase_err)
    );

    int checks = 0;
    int fails  = 0;

    // Arithmetic model of the requirements
    bit m_act, m_pend;
    int m_ph, m_P, m_filt, m_bnd, m_err, m_lim, m_tc;
    int m_off [NT];

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sx24(logic [DW-1:0] v);
        return int'($signed(v));
    endfunction

    function automatic int exp_trig();
        int v = 0;
        for (int i = 0; i < NT; i++) begin
            int ot  = m_off[i] * UT;
            int tgt = (ot < 0) ? m_P + ot : ot;
            if (m_act && m_ph == tgt) v |= (1 << i);
        end
        return v;
    endfunction

    task automatic model_edge();
        int oldP = m_P;
        int pn;
        if (!m_act) begin
            if (sync_rd) begin m_act = 1; m_ph = 1; end
        end else if (m_pend) begin
            m_filt = m_filt + ((m_bnd - m_filt) >>> m_tc);          // R5
            pn = oldP + m_filt + (m_bnd >>> 4);                      // R6
            if (pn < PMIN) pn = PMIN;
            if (pn > 24'hFFFFFF) pn = 24'hFFFFFF;
            m_P = pn;
            m_pend = 0;
            m_ph = (m_ph >= oldP - 1) ? 0 : m_ph + 1;
        end else begin
            if (sync_rd) begin
                m_err = (2 * m_ph < oldP) ? m_ph : m_ph - oldP;       // R3
                if (m_err > m_lim) m_bnd = m_lim;                     // R4
                else if (m_err < -m_lim) m_bnd = -m_lim;
                else m_bnd = m_err;
                m_pend = 1;
            end
            m_ph = (m_ph >= oldP - 1) ? 0 : m_ph + 1;
        end
        if (cfg_we) begin                                            // R9
            case (int'(cfg_addr))
                0: m_P = (int'(cfg_wdata) < PMIN) ? PMIN : int'(cfg_wdata);
                1: m_lim = int'(cfg_wdata);
                2: m_tc = int'(cfg_wdata[4:0]);
                default: m_off[int'(cfg_addr) - 4] = int'($signed(cfg_wdata[15:0]));
            endcase
        end
    endtask

    task automatic step(bit s, string tag);
        sync_rd = s;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        sync_rd = 1'b0;
        cfg_we  = 1'b0;
        chk({tag, " trig"}, int'(trig), exp_trig());
        chk({tag, " phase_err"}, sx24(phase_err), m_err);
    endtask

    task automatic wr(int a, int d);
        cfg_we    = 1'b1;
        cfg_addr  = AW'(a);
        cfg_wdata = DW'(d);
        step(0, "R9");
    endtask

    task automatic wait_phase(int v, string tag);
        for (int n = 0; n < 2000 && m_ph != v; n++) step(0, tag);
        step(1, tag);
    endtask

    task automatic measure(int exp, string tag);
        int n = 0;
        for (int k = 0; k < 300 && !trig[0]; k++) step(0, tag);
        step(0, tag); n = 1;
        while (!trig[0] && n < 300) begin step(0, tag); n++; end
        chk({tag, " trigger spacing"}, n, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; sync_rd = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        m_act = 0; m_pend = 0; m_ph = 0; m_P = PR; m_filt = 0; m_bnd = 0; m_err = 0;
        m_lim = 'h400000; m_tc = 10;
        for (int i = 0; i < NT; i++) m_off[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: quiet before the first sync read
        chk("R1 reset trig", int'(trig), 0);
        chk("R1 reset phase_err", sx24(phase_err), 0);
        for (int k = 0; k < 20; k++) step(0, "R1");

        // R9: configuration writes
        wr(2, 2);
        wr(4, 0);
        wr(5, -3);
        wr(6, 2);
        wr(7, -1);

        // R1: first read starts tracking, error stays zero
        step(1, "R1");
        chk("R1 first read phase_err", sx24(phase_err), 0);
        for (int k = 0; k < 2 * PR; k++) step(0, "R7");

        // R2: on-time read
        wait_phase(0, "R2");
        chk("R2 on-time error", sx24(phase_err), 0);
        for (int k = 0; k < PR; k++) step(0, "R7");

        // R3: late and early reads
        wait_phase(3, "R3");
        chk("R3 late error", sx24(phase_err), 3);
        for (int k = 0; k < PR; k++) step(0, "R5");
        wait_phase(m_P - 5, "R3");
        chk("R3 early error", sx24(phase_err), -5);
        for (int k = 0; k < PR; k++) step(0, "R6");

        // R4: clamp feeds the loop, raw value still reported
        wr(1, 2);
        wait_phase(7, "R4");
        chk("R4 raw error reported", sx24(phase_err), 7);
        for (int k = 0; k < 2 * PR; k++) step(0, "R4");

        // R8 / R10: read in the update clock is dropped, the next one is taken
        wait_phase(2, "R8");
        step(1, "R8");
        chk("R8 ignored read keeps error", sx24(phase_err), 2);
        step(1, "R10");
        chk("R10 read after update accepted", sx24(phase_err), 4);
        for (int k = 0; k < 2 * PR; k++) step(0, "R7");

        // R6: drive the period onto its floor
        wr(1, 'h400000);
        wr(2, 0);
        for (int r = 0; r < 8; r++) begin
            wait_phase(m_P - (m_P / 2 - 1), "R6");
            for (int k = 0; k < 4; k++) step(0, "R6");
        end
        measure(PMIN, "R6");

        // R9: period writes, with the floor applied to small values
        wr(0, 3);
        measure(PMIN, "R9");
        wr(0, 30);
        measure(30, "R9");
        for (int k = 0; k < 30; k++) step(0, "R7");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule